// File: doc/BRIEF.md
# Shared Overflow Flag Multiplexer

This block keeps an overflow state for each channel of a stereo converter and reports both states on one shared, active-low, open-drain flag. Each channel is flagged by a one-cycle overflow pulse. It stays flagged until a timeout, counted in ticks of a slow timebase, has expired. The block only ever pulls the shared line low. Several devices can therefore share one pull-up resistor as a wired-OR.

The flag is time-multiplexed against the frame clock. In each half frame, the flag carries one channel's state, and it changes only at a fixed bit-clock slot after the frame-clock edge. A receiver latches the value on the next frame-clock edge. The serial format decides both the slot position and which channel is carried in each half.

All logic runs on one system clock. The bit clock arrives as a one-cycle `bit_tick` strobe. The frame clock `lrck` is sampled on those strobes.

Top module: `ovf_flag_mux`

## Requirements
- R1: Reset clears both channel states and releases the flag (`flag_pull` = 0). After reset the sampled frame level is taken as low.
- R2: Left-justified format (`fmt_i2s` = 0): `flag_pull` changes on the first bit tick after the bit tick that saw a frame-clock level change. While `lrck` is low it carries the right-channel state; while high, the left.
- R3: I2S format (`fmt_i2s` = 1): `flag_pull` changes on the second bit tick after the edge tick. While `lrck` is low it carries the left-channel state; while high, the right.
- R4: A pulse on `ovf_l` or `ovf_r` flags that channel on the next clock, independently of the other channel.
- R5: A flagged channel is released on the TIMEOUT-th `tmo_tick` after its most recent load. It is never released without a tick.
- R6: An overflow pulse on a channel that is already flagged reloads that channel's count to the full TIMEOUT.
- R7: When a pulse leaves both channels flagged, both counts are loaded with TIMEOUT. While both are flagged, they remain equal and are released on the same clock.
- R8: `flag_pull` changes only on a bit tick at the format's slot. It holds its value on every other cycle, including the edge tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovf_l | input | 1 | Left-channel overflow pulse |
| ovf_r | input | 1 | Right-channel overflow pulse |
| tmo_tick | input | 1 | Timeout timebase strobe |
| bit_tick | input | 1 | One-cycle strobe per bit-clock period |
| lrck | input | 1 | Frame clock level, sampled on `bit_tick` |
| fmt_i2s | input | 1 | 1 = I2S slotting, 0 = left-justified |
| flag_pull | output | 1 | 1 = pull the shared flag line low |

## Verification
The bench aims first at the slot position. A design that updates on the edge tick, or one bit late, shows the new value before the expected slot or the old one after it. It also aims at the channel-to-half mapping in both formats, where a swapped mapping shows the idle channel's state. Retriggering a channel that is already flagged is checked at a point where a missing reload would already have released it. The joint release is checked at a point where the earlier channel would have expired if the second entry had not reloaded both counts. A reset in the middle of an overflow must leave no channel flagged when frames resume.

// File: rtl/ovf_flag_mux.sv
module ovf_flag_mux #(
  parameter int TIMEOUT = 680,
  parameter int POS_W   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf_l,
  input  logic ovf_r,
  input  logic tmo_tick,
  input  logic bit_tick,
  input  logic lrck,
  input  logic fmt_i2s,
  output logic flag_pull
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] LOAD = TW'(TIMEOUT);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [TW-1:0]    cnt_l, cnt_r;
  logic             st_l, st_r;
  logic             lr_q, flag_q;
  logic [POS_W-1:0] pos, pos_n, slot;
  logic             edge_seen, show_r, both_next, load_all;

  assign both_next = (st_l | ovf_l) & (st_r | ovf_r);
  assign load_all  = both_next & (ovf_l | ovf_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_l  <= 1'b0;
      cnt_l <= '0;
    end else if (ovf_l || load_all) begin
      st_l  <= 1'b1;
      cnt_l <= LOAD;
    end else if (st_l && tmo_tick) begin
      cnt_l <= cnt_l - 1'b1;
      if (cnt_l <= 1) st_l <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_r  <= 1'b0;
      cnt_r <= '0;
    end else if (ovf_r || load_all) begin
      st_r  <= 1'b1;
      cnt_r <= LOAD;
    end else if (st_r && tmo_tick) begin
      cnt_r <= cnt_r - 1'b1;
      if (cnt_r <= 1) st_r <= 1'b0;
    end
  end

  assign edge_seen = lrck ^ lr_q;
  assign pos_n     = edge_seen ? '0 : ((pos == POS_MAX) ? pos : pos + 1'b1);
  assign slot      = fmt_i2s ? POS_W'(2) : POS_W'(1);
  assign show_r    = fmt_i2s ? lrck : ~lrck;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_q   <= 1'b0;
      pos    <= POS_MAX;
      flag_q <= 1'b0;
    end else if (bit_tick) begin
      lr_q <= lrck;
      pos  <= pos_n;
      if (pos_n == slot) flag_q <= show_r ? st_r : st_l;
    end
  end

  assign flag_pull = flag_q;
endmodule

module ovf_flag_mux_chk (
  input logic clk,
  input logic rst_n,
  input logic ovf_l,
  input logic ovf_r,
  input logic tmo_tick,
  input logic bit_tick,
  input logic lrck,
  input logic lr_q,
  input logic st_l,
  input logic st_r,
  input logic flag_pull
);
  AST_RESET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> !flag_pull); // R1
  AST_EDGE_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (bit_tick && (lrck != lr_q)) |=> $stable(flag_pull)); // R2
  AST_LEFT_ENTER: assert property (@(posedge clk) disable iff (!rst_n) ovf_l |=> st_l); // R4
  AST_RIGHT_ENTER: assert property (@(posedge clk) disable iff (!rst_n) ovf_r |=> st_r); // R4
  AST_NO_TICK_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (st_l && !tmo_tick) |=> st_l); // R5
  AST_JOINT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (st_l && st_r) |=> (st_l == st_r)); // R7
  AST_FLAG_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !bit_tick |=> $stable(flag_pull)); // R8
endmodule

bind ovf_flag_mux ovf_flag_mux_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ovf_l(ovf_l), .ovf_r(ovf_r), .tmo_tick(tmo_tick),
  .bit_tick(bit_tick), .lrck(lrck), .lr_q(lr_q), .st_l(st_l), .st_r(st_r),
  .flag_pull(flag_pull)
);

// File: tb/test_ovf_flag_mux.sv
module test_ovf_flag_mux;
  localparam int NB = 8;
  localparam int NV = 14;
  // {fmt, lvl, pulse_l, pulse_r, ticks[1:0], expected flag}
  localparam logic [6:0] VEC [NV] = '{
    7'b0010000, 7'b0100011, 7'b0001001, 7'b0100101, 7'b0000010, 7'b0100000,
    7'b1001010, 7'b1100001, 7'b1001100, 7'b1100001, 7'b1010001, 7'b1100101,
    7'b1000010, 7'b1100000
  };
  localparam string TAGS [NV] = '{
    "R2/R4", "R2/R5", "R2/R7", "R2/R7", "R2/R7", "R2",
    "R3", "R3/R4", "R3/R6", "R3/R6", "R3/R7", "R3/R7", "R3/R7", "R3"
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ovf_l = 1'b0, ovf_r = 1'b0, tmo_tick = 1'b0, bit_tick = 1'b0;
  logic lrck = 1'b0, fmt_i2s = 1'b0;
  logic flag_pull;
  int checks = 0, errors = 0;
  logic prev;

  always #4 clk = ~clk;

  ovf_flag_mux #(.TIMEOUT(3), .POS_W(6)) i_ovf_flag_mux (
    .clk(clk), .rst_n(rst_n), .ovf_l(ovf_l), .ovf_r(ovf_r), .tmo_tick(tmo_tick),
    .bit_tick(bit_tick), .lrck(lrck), .fmt_i2s(fmt_i2s), .flag_pull(flag_pull)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flag_pull=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic pulse(input logic pl, input logic pr, input int nt);
    @(negedge clk); ovf_l = pl; ovf_r = pr;
    @(negedge clk); ovf_l = 1'b0; ovf_r = 1'b0;
    for (int i = 0; i < nt; i++) begin
      @(negedge clk); tmo_tick = 1'b1;
      @(negedge clk); tmo_tick = 1'b0;
    end
  endtask

  task automatic half(input logic lvl, input logic exp, input string tag);
    int slot;
    slot = fmt_i2s ? 2 : 1;
    for (int b = 0; b < NB; b++) begin
      @(negedge clk); bit_tick = 1'b1; lrck = lvl;
      @(negedge clk); bit_tick = 1'b0;
      if (b < slot) check(flag_pull, prev, "R8 hold before slot");
      else check(flag_pull, exp, tag);
    end
    prev = exp;
  endtask

  initial begin
    #(8ns * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    prev = 1'b0;
    repeat (4) @(negedge clk);
    check(flag_pull, 1'b0, "R1 reset release");
    rst_n = 1'b1;
    half(1'b1, 1'b0, "R1 idle after reset");

    for (int v = 0; v < NV; v++) begin
      fmt_i2s = VEC[v][6];
      pulse(VEC[v][4], VEC[v][3], int'(VEC[v][2:1]));
      half(VEC[v][5], VEC[v][0], TAGS[v]);
    end

    // Reset in the middle of an overflow
    fmt_i2s = 1'b0;
    pulse(1'b1, 1'b1, 0);
    half(1'b0, 1'b1, "R2 before mid reset");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); check(flag_pull, 1'b0, "R1 mid reset release");
    rst_n = 1'b1;
    prev = 1'b0;
    half(1'b1, 1'b0, "R1 left cleared");
    half(1'b0, 1'b0, "R1 right cleared");

    // Pulse mid-half must not move the flag before the next slot
    pulse(1'b1, 1'b0, 0);
    @(negedge clk); check(flag_pull, 1'b0, "R8 no change off slot");
    half(1'b1, 1'b1, "R2 left shown high half");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule